// File: doc/BRIEF.md
# Posted-CAS Data Latency Pipeline

This block turns accepted Read and Write commands into cycle-exact data windows for a double-data-rate memory interface. Each command is posted: its data does not move until a programmed number of cycles later. The read latency is the additive latency plus the CAS latency, and the write latency is one cycle shorter. Every clock cycle carries two data beats, one on each clock edge. A burst of 4 beats therefore occupies 2 cycles, and a burst of 8 beats occupies 4 cycles.

Scheduled bursts travel down a shift pipeline that has one slot per cycle, so several bursts can be in flight at the same time. In every cycle of a data window the block reports whether the window is a read or a write, and whether this is the final cycle of the burst. It also gives the column offset of the beat on each edge, following either sequential or interleaved wrap order. For writes it gives a per-beat commit enable that honours the data mask. A command whose window would land on a cycle that is already taken is discarded, and an error pulse is raised.

The mode settings arrive as plain register inputs. Each command takes the settings present in its own command cycle.

Top module: `cas_latency_pipe`

## Requirements
- R1: For a Read accepted in cycle n, `rd_dv` is high from cycle n+RL, where RL = CL_eff + AL_eff.
- R2: For a Write accepted in cycle n, `wr_dv` is high from cycle n+RL-1.
- R3: A burst keeps its strobe high for 2 consecutive cycles when `cfg_burst8`=0 and for 4 cycles when it is 1. `burst_last` is high only in the final cycle of the burst.
- R4: Sequential order, with start column s and beat b, where in burst cycle k the rising-edge beat is b=2k and the falling-edge beat is b=2k+1. With 8-beat bursts the column is (s+b) mod 8. With 4-beat bursts, bit 2 of the column is taken from s and bits 1:0 are (s+b) mod 4. Both column outputs are 0 outside data windows.
- R5: Interleaved order (`cfg_interleave`=1), with the same beat numbering as R4. With 8-beat bursts the column is s XOR b. With 4-beat bursts, bit 2 comes from s and bits 1:0 are s[1:0] XOR b.
- R6: `wr_beat_en[0]` (rising-edge beat) is `wr_dv` AND NOT `dm_in[0]`. `wr_beat_en[1]` (falling-edge beat) is `wr_dv` AND NOT `dm_in[1]`. Both bits are 0 outside write windows.
- R7: Commands spaced exactly one burst duration apart give back-to-back data with no idle cycle and no error. The same holds for a Read issued one cycle less than a burst after a Write, and several bursts may be in flight together.
- R8: If any data cycle of a new command coincides with a cycle already scheduled, the command is dropped whole and `overlap_err` is high in the cycle after the command. A read window and a write window never share a cycle.
- R9: A CAS latency setting below 3 acts as 3, a setting above 7 acts as 7, and an additive latency setting above 6 acts as 6.
- R10: While `rst_n` is low at a clock edge, every output is 0 after that edge and every scheduled burst is discarded.
- R11: Latency, burst length and order are taken from the configuration present in the command's own cycle. Later configuration changes do not alter bursts already scheduled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cas_lat | input | 3 | CAS latency in cycles (clamped to 3..7) |
| cfg_add_lat | input | 3 | Additive latency in cycles (clamped to 0..6) |
| cfg_burst8 | input | 1 | 1: 8-beat bursts, 0: 4-beat bursts |
| cfg_interleave | input | 1 | 1: interleaved order, 0: sequential order |
| cmd_valid | input | 1 | A Read or Write command is accepted this cycle |
| cmd_write | input | 1 | 1: Write, 0: Read |
| cmd_col | input | 3 | Starting column low bits |
| dm_in | input | 2 | Data mask for this cycle's beats (bit 0 rising edge, bit 1 falling edge) |
| rd_dv | output | 1 | Read data valid this cycle |
| wr_dv | output | 1 | Write data capture window this cycle |
| burst_last | output | 1 | Final cycle of the current burst |
| col_rise | output | 3 | Column offset of the rising-edge beat |
| col_fall | output | 3 | Column offset of the falling-edge beat |
| wr_beat_en | output | 2 | Write beats to commit (bit 0 rising edge, bit 1 falling edge) |
| overlap_err | output | 1 | Previous cycle's command collided and was dropped |

## Verification
The first patterns are single isolated Reads and Writes at the minimum latency. These separate the read delay from the one-cycle-shorter write delay and confirm the burst length and the edge-to-beat mapping. Commands are then spaced exactly one burst apart, and Write-to-Read pairs are spaced one cycle less than a burst, in both orders and lengths. These runs show that back-to-back windows join without a gap or a false error. Closer spacings, including Read-then-Write turnarounds, must trigger the drop-and-flag path. Clamped settings, configuration changes while bursts are in flight, a reset during a pending burst and a long run of mixed random commands and settings check latching at command time and the discarding of pending work.

// File: rtl/cas_lat_pkg.sv
// Package: shared slot type and beat-order helper for the posted-CAS latency pipeline.
// Assumes bursts of at most 8 beats, two beats per clock cycle.
package cas_lat_pkg;

    localparam int BURST_MAX = 8;
    localparam int COL_W     = $clog2(BURST_MAX);
    localparam int CYC_MAX   = BURST_MAX / 2;
    localparam int CYC_W     = $clog2(CYC_MAX);

    // One pipeline slot: the data cycle of a scheduled burst
    typedef struct packed {
        logic             vld;
        logic             wr;
        logic [CYC_W-1:0] cyc;
        logic [COL_W-1:0] col;
        logic             bl8;
        logic             ilv;
        logic             last;
    } slot_t;

    // Column reached by a given beat of a burst, in wrap order
    function automatic logic [COL_W-1:0] beat_col(
        input logic [COL_W-1:0] start,
        input logic [COL_W-1:0] beat,
        input logic             bl8,
        input logic             ilv
    );
        logic [COL_W-1:0] wrap_mask;
        logic [COL_W-1:0] mixed;
        wrap_mask = bl8 ? {COL_W{1'b1}} : {1'b0, {(COL_W-1){1'b1}}};
        mixed     = ilv ? (start ^ beat) : (start + beat);
        return (start & ~wrap_mask) | (mixed & wrap_mask);
    endfunction

endpackage

// File: rtl/cas_lat_calc.sv
// Module: cas_lat_calc
// Clamps the programmed CAS and additive latencies to their legal ranges and
// derives read latency (sum) and write latency (one cycle less).
// Assumes CL_MIN >= 2 so that the write latency is never below 1.
module cas_lat_calc #(
    parameter int CFG_W  = 3,
    parameter int CL_MIN = 3,
    parameter int CL_MAX = 7,
    parameter int AL_MAX = 6,
    parameter int LAT_W  = 4
) (
    input  logic [CFG_W-1:0] cfg_cas_lat,
    input  logic [CFG_W-1:0] cfg_add_lat,
    output logic [LAT_W-1:0] rd_lat,
    output logic [LAT_W-1:0] wr_lat
);

    localparam logic [CFG_W-1:0] CL_LO = CFG_W'(CL_MIN);
    localparam logic [CFG_W-1:0] CL_HI = CFG_W'(CL_MAX);
    localparam logic [CFG_W-1:0] AL_HI = CFG_W'(AL_MAX);

    logic [CFG_W-1:0] cl_eff;
    logic [CFG_W-1:0] al_eff;

    // Clamp each setting into its legal range
    always_comb begin
        if (cfg_cas_lat < CL_LO)      cl_eff = CL_LO;
        else if (cfg_cas_lat > CL_HI) cl_eff = CL_HI;
        else                          cl_eff = cfg_cas_lat;
        al_eff = (cfg_add_lat > AL_HI) ? AL_HI : cfg_add_lat;
    end

    // Read latency is the sum; write latency trails it by one
    always_comb begin
        rd_lat = LAT_W'(cl_eff) + LAT_W'(al_eff);
        wr_lat = rd_lat - LAT_W'(1);
    end

endmodule

// File: rtl/cas_slot_pipe.sv
// Module: cas_slot_pipe
// Shift pipeline with one slot per clock cycle. Slot 0 is the current data
// cycle. A command with latency L fills slots L-1 .. L-2+N (N = burst cycles)
// of the post-shift image, so slot 0 reaches it L cycles after the command.
// A command that finds any target slot taken is dropped and flagged next cycle.
// Assumes DEPTH >= maximum latency + maximum burst cycles - 1.
module cas_slot_pipe
    import cas_lat_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic             ins_wr,
    input  logic [LAT_W-1:0] ins_lat,
    input  logic [COL_W-1:0] ins_col,
    input  logic             ins_bl8,
    input  logic             ins_ilv,
    output slot_t            head,
    output logic             overlap_err
);

    localparam int POS_W = $clog2(DEPTH);

    slot_t sr      [DEPTH];
    slot_t shifted [DEPTH];
    slot_t nxt     [DEPTH];
    logic  collide;

    // Advance every slot one step towards the head
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_shift
            if (g < DEPTH - 1) begin : g_mid
                assign shifted[g] = sr[g+1];
            end else begin : g_tail
                assign shifted[g] = '0;
            end
        end
    endgenerate

    // Detect collisions and place a new burst into the shifted image
    always_comb begin : p_sched
        int n_cyc;
        int pos;
        n_cyc   = ins_bl8 ? CYC_MAX : CYC_MAX / 2;
        collide = 1'b0;
        nxt     = shifted;
        for (int j = 0; j < CYC_MAX; j++) begin
            pos = int'(ins_lat) - 1 + j;
            if (j < n_cyc && pos >= 0 && pos < DEPTH) begin
                if (shifted[POS_W'(pos)].vld) collide = 1'b1;
            end
        end
        if (ins_en && !collide) begin
            for (int j = 0; j < CYC_MAX; j++) begin
                pos = int'(ins_lat) - 1 + j;
                if (j < n_cyc && pos >= 0 && pos < DEPTH) begin
                    nxt[POS_W'(pos)].vld  = 1'b1;
                    nxt[POS_W'(pos)].wr   = ins_wr;
                    nxt[POS_W'(pos)].cyc  = CYC_W'(j);
                    nxt[POS_W'(pos)].col  = ins_col;
                    nxt[POS_W'(pos)].bl8  = ins_bl8;
                    nxt[POS_W'(pos)].ilv  = ins_ilv;
                    nxt[POS_W'(pos)].last = (j == n_cyc - 1);
                end
            end
        end
    end

    // Register the pipeline and the collision pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
            overlap_err <= 1'b0;
        end else begin
            sr          <= nxt;
            overlap_err <= ins_en && collide;
        end
    end

    assign head = sr[0];

endmodule

// File: rtl/cas_beat_order.sv
// Module: cas_beat_order
// Converts the head slot into the column offsets of the rising-edge and
// falling-edge beats of the current cycle. Outputs are 0 when the slot is empty.
module cas_beat_order
    import cas_lat_pkg::*;
(
    input  slot_t            head,
    output logic [COL_W-1:0] col_rise,
    output logic [COL_W-1:0] col_fall
);

    logic [COL_W-1:0] cols [2];

    // One column generator per clock edge: beat = 2*cycle + edge
    generate
        for (genvar e = 0; e < 2; e++) begin : g_edge
            logic [COL_W-1:0] beat;
            assign beat    = {head.cyc, 1'(e)};
            assign cols[e] = head.vld ? beat_col(head.col, beat, head.bl8, head.ilv)
                                      : '0;
        end
    endgenerate

    assign col_rise = cols[0];
    assign col_fall = cols[1];

endmodule

// File: rtl/cas_latency_pipe.sv
// Module: cas_latency_pipe (top)
// Schedules posted Read/Write bursts: read data at AL+CL cycles, write data
// one cycle earlier, burst of 2 or 4 cycles, beat columns in sequential or
// interleaved order, write beats masked by dm_in. Colliding commands are
// dropped and flagged. Configuration is sampled per command.
module cas_latency_pipe
    import cas_lat_pkg::*;
#(
    parameter int CFG_W  = 3,
    parameter int CL_MIN = 3,
    parameter int CL_MAX = 7,
    parameter int AL_MAX = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_cas_lat,
    input  logic [CFG_W-1:0] cfg_add_lat,
    input  logic             cfg_burst8,
    input  logic             cfg_interleave,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [1:0]       dm_in,
    output logic             rd_dv,
    output logic             wr_dv,
    output logic             burst_last,
    output logic [COL_W-1:0] col_rise,
    output logic [COL_W-1:0] col_fall,
    output logic [1:0]       wr_beat_en,
    output logic             overlap_err
);

    localparam int LAT_W = $clog2(CL_MAX + AL_MAX + 1);
    localparam int DEPTH = CL_MAX + AL_MAX + CYC_MAX - 1;

    logic [LAT_W-1:0] rd_lat;
    logic [LAT_W-1:0] wr_lat;
    logic [LAT_W-1:0] cmd_lat;
    slot_t            head;

    cas_lat_calc #(
        .CFG_W  (CFG_W),
        .CL_MIN (CL_MIN),
        .CL_MAX (CL_MAX),
        .AL_MAX (AL_MAX),
        .LAT_W  (LAT_W)
    ) lat_i (
        .cfg_cas_lat (cfg_cas_lat),
        .cfg_add_lat (cfg_add_lat),
        .rd_lat      (rd_lat),
        .wr_lat      (wr_lat)
    );

    // Pick the latency that applies to this command's direction
    assign cmd_lat = cmd_write ? wr_lat : rd_lat;

    cas_slot_pipe #(
        .DEPTH (DEPTH),
        .LAT_W (LAT_W)
    ) pipe_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ins_en      (cmd_valid),
        .ins_wr      (cmd_write),
        .ins_lat     (cmd_lat),
        .ins_col     (cmd_col),
        .ins_bl8     (cfg_burst8),
        .ins_ilv     (cfg_interleave),
        .head        (head),
        .overlap_err (overlap_err)
    );

    cas_beat_order order_i (
        .head     (head),
        .col_rise (col_rise),
        .col_fall (col_fall)
    );

    // Decode the head slot into direction strobes and the burst-end marker
    always_comb begin
        rd_dv      = head.vld && !head.wr;
        wr_dv      = head.vld && head.wr;
        burst_last = head.vld && head.last;
    end

    // Commit only write beats whose mask bit is low
    assign wr_beat_en = {2{wr_dv}} & ~dm_in;

endmodule

// File: rtl/cas_latency_pipe_chk.sv
// Module: cas_latency_pipe_chk
// Protocol checker bound to the top module; observes ports only.
module cas_latency_pipe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       rd_dv,
    input logic       wr_dv,
    input logic       burst_last,
    input logic [2:0] col_rise,
    input logic [2:0] col_fall,
    input logic [1:0] wr_beat_en,
    input logic       overlap_err
);

    // R3: the burst-end marker only appears inside a data window
    a_r3_last_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        burst_last |-> (rd_dv || wr_dv));

    // R3: a read window is never shorter than two cycles
    a_r3_min_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_dv) |=> rd_dv);

    // R8: read and write windows never share a cycle
    a_r8_one_window: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_dv && wr_dv));

    // R8: an error pulse always follows a presented command
    a_r8_err_has_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_err |-> $past(cmd_valid));

    // R6: write beats are committed only in write windows
    a_r6_mask_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_beat_en != 2'b00) |-> wr_dv);

    // R4: the two edges of one cycle carry an even and an odd beat
    a_r4_edge_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dv || wr_dv) |-> (col_rise[0] != col_fall[0]));

endmodule

bind cas_latency_pipe cas_latency_pipe_chk chk_i (.*);

// File: tb/cas_latency_pipe_tb_top.sv
// Bench: behavioural reference schedule indexed by absolute cycle, compared
// against every output on every clock.
module cas_latency_pipe_tb_top;

    localparam int MAXC = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_cas_lat = 3'd3;
    logic [2:0] cfg_add_lat = 3'd0;
    logic       cfg_burst8 = 1'b0;
    logic       cfg_interleave = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic [2:0] cmd_col = 3'd0;
    logic [1:0] dm_in = 2'b00;
    logic       rd_dv, wr_dv, burst_last, overlap_err;
    logic [2:0] col_rise, col_fall;
    logic [1:0] wr_beat_en;

    always #5 clk = ~clk;

    cas_latency_pipe dut_i (.*);

    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string phase = "R10 reset";

    // Reference schedule: 0 idle, 1 read, 2 write
    int ek   [MAXC];
    int ecr  [MAXC];
    int ecf  [MAXC];
    bit elst [MAXC];
    bit eilv [MAXC];
    bit eerr [MAXC];

    int m_cl = 3, m_al = 0;
    bit m_b8 = 0, m_il = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, logic [7:0] act, int exp);
        n_chk++;
        if (act !== 8'(exp)) begin
            n_fail++;
            $display("FAIL %s [%s] cycle %0d: actual %0d expected %0d", tag, phase, cyc, act, exp);
        end
    endtask

    function automatic int eff_rl();
        int cl, al;
        cl = (m_cl < 3) ? 3 : ((m_cl > 7) ? 7 : m_cl);
        al = (m_al > 6) ? 6 : m_al;
        return cl + al;
    endfunction

    function automatic int col_of(int s, int b, bit b8, bit il);
        int len, base, lo;
        len  = b8 ? 8 : 4;
        base = b8 ? 0 : (s / 4) * 4;
        lo   = s % len;
        if (il) return base + (lo ^ b);
        return base + ((lo + b) % len);
    endfunction

    task automatic compare(int c);
        int k;
        k = ek[c];
        chk("R1 rd_dv", rd_dv, k == 1);
        chk("R2 wr_dv", wr_dv, k == 2);
        chk("R3 burst_last", burst_last, elst[c]);
        chk(eilv[c] ? "R5 col_rise" : "R4 col_rise", col_rise, ecr[c]);
        chk(eilv[c] ? "R5 col_fall" : "R4 col_fall", col_fall, ecf[c]);
        chk("R6 wr_beat_en", wr_beat_en, (k == 2) ? (~int'(dm_in) & 3) : 0);
        chk("R8 overlap_err", overlap_err, eerr[c]);
    endtask

    task automatic schedule(int c, bit w, int col);
        int lat, nb;
        bit hit;
        lat = w ? eff_rl() - 1 : eff_rl();
        nb  = m_b8 ? 4 : 2;
        hit = 0;
        for (int j = 0; j < nb; j++) if (ek[c+lat+j] != 0) hit = 1;
        if (hit) begin
            eerr[c+1] = 1;
        end else begin
            for (int j = 0; j < nb; j++) begin
                ek[c+lat+j]   = w ? 2 : 1;
                ecr[c+lat+j]  = col_of(col, 2*j, m_b8, m_il);
                ecf[c+lat+j]  = col_of(col, 2*j+1, m_b8, m_il);
                elst[c+lat+j] = (j == nb - 1);
                eilv[c+lat+j] = m_il;
            end
        end
    endtask

    task automatic step(bit v, bit w, int col, logic [1:0] dm);
        @(negedge clk);
        cfg_cas_lat    = 3'(m_cl);
        cfg_add_lat    = 3'(m_al);
        cfg_burst8     = m_b8;
        cfg_interleave = m_il;
        cmd_valid      = v;
        cmd_write      = w;
        cmd_col        = 3'(col);
        dm_in          = dm;
        #1;
        compare(cyc);
        if (v) schedule(cyc, w, col);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 2'(i));
    endtask

    task automatic do_reset(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst_n = 1'b0;
            cmd_valid = 1'b0;
            #1;
            compare(cyc);
            for (int c = cyc + 1; c < MAXC; c++) begin
                ek[c] = 0; ecr[c] = 0; ecf[c] = 0; elst[c] = 0; eilv[c] = 0; eerr[c] = 0;
            end
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_cfg(int cl, int al, bit b8, bit il);
        m_cl = cl; m_al = al; m_b8 = b8; m_il = il;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        // R10: outputs low while held in reset
        do_reset(4);

        phase = "R1 R3 R4 single read CL3 AL0 BL4";
        set_cfg(3, 0, 0, 0);
        step(1, 0, 1, 0); idle(12);

        phase = "R2 R6 single write with mask";
        step(1, 1, 2, 0); step(0, 0, 0, 2'b01); step(0, 0, 0, 2'b10);
        step(0, 0, 0, 2'b11); step(0, 0, 0, 2'b00); idle(10);

        phase = "R5 R7 gapless interleaved BL8 CL5 AL2";
        set_cfg(5, 2, 1, 1);
        step(1, 0, 5, 0); idle(3); step(1, 0, 3, 0); idle(3); step(1, 0, 6, 0); idle(20);

        phase = "R7 write then read spaced one less than burst";
        set_cfg(4, 1, 0, 0);
        step(1, 1, 7, 2'b10); step(1, 0, 6, 2'b01); idle(15);
        set_cfg(6, 3, 1, 0);
        step(1, 1, 3, 0); idle(2); step(1, 0, 5, 2'b11); idle(25);

        phase = "R8 read then write too close";
        set_cfg(3, 2, 0, 1);
        step(1, 0, 2, 0); idle(1); step(1, 1, 4, 0); idle(15);

        phase = "R8 reads spaced one cycle";
        step(1, 0, 1, 0); step(1, 0, 2, 0); step(1, 1, 0, 0); idle(15);

        phase = "R9 clamped latencies";
        set_cfg(1, 7, 0, 0);
        step(1, 0, 3, 0); idle(15);
        set_cfg(0, 0, 1, 0);
        step(1, 1, 4, 2'b01); idle(15);
        set_cfg(7, 6, 1, 1);
        step(1, 0, 7, 0); idle(22);

        phase = "R11 config change in flight";
        set_cfg(7, 4, 1, 1);
        step(1, 0, 2, 0);
        set_cfg(3, 0, 0, 0);
        step(0, 0, 0, 0); step(1, 1, 5, 2'b10); idle(25);

        phase = "R10 reset with burst pending";
        set_cfg(6, 4, 1, 0);
        step(1, 0, 1, 0); idle(3);
        do_reset(2);
        idle(20);

        phase = "R7 R8 R11 mixed random traffic";
        for (int i = 0; i < 600; i++) begin
            if (i % 60 == 0)
                set_cfg(int'($urandom % 8), int'($urandom % 8), 1'($urandom % 2), 1'($urandom % 2));
            step(($urandom % 3) == 0, 1'($urandom % 2), int'($urandom % 8), 2'($urandom % 4));
        end
        idle(25);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule